// File: doc/BRIEF.md
# Processor exception entry sequencer

This block performs the entry and return sequence for the exceptions of a small processor core. Each cycle it looks at seven request lines (reset, undefined instruction, software interrupt, prefetch abort, data abort, normal interrupt and fast interrupt), together with the core's current PC and status word. When a request is eligible, the block picks one winner by a fixed priority and does the following in one cycle:

- It copies the status word and a return address into a bank that belongs to the winner's target mode.
- It builds the new status word: the new mode, with interrupt masks set.
- It emits the vector address and raises a one-cycle `taken` pulse that carries the exception identifier.

The core commits the new status word and PC from these outputs. The register file, decode and memory stay outside the block.

A return command reads the bank of the mode in the current status word. The block then hands back the saved status word and a PC. The PC is the stored return address as it is, or that address minus 4, chosen by the command. After every entry or return, the block spends one cycle in which it ignores new requests, so the core can commit the update.

The sequencer has three named states:

| State | Role |
| --- | --- |
| `ST_IDLE` | Accepts requests and return commands. |
| `ST_ENTRY` | Presents an entry for one cycle. |
| `ST_RETURN` | Presents a restore for one cycle. |

Its transitions are:

| Transition | From | To | Condition |
| --- | --- | --- | --- |
| take | `ST_IDLE` | `ST_ENTRY` | An eligible request is present. |
| resume | `ST_IDLE` | `ST_RETURN` | A return command is present, no eligible request is present, and the current mode has a bank. |
| settle | `ST_ENTRY` | `ST_IDLE` | Always. |
| settle | `ST_RETURN` | `ST_IDLE` | Always. |

Top module: `exc_entry_seq`

## Requirements
- R1: After reset release, `taken` and `restore_valid` are 0 until the first request or return command is accepted.
- R2: The identifier codes are reset=0, undefined=1, software interrupt=2, prefetch abort=3, data abort=4, normal interrupt=6, fast interrupt=7. When eligible requests arrive together, the winner is taken in this order: reset, data abort, fast interrupt, normal interrupt, prefetch abort, undefined, software interrupt.
- R3: `vector` equals VEC_BASE + 4 × identifier.
- R4: The status word keeps the mode in bits [4:0]. The mode codes are user=0x00, system=0x01, fast-interrupt=0x02, interrupt=0x03, supervisor=0x04, abort=0x05, undefined=0x06. The new mode is set as follows:
  - supervisor for reset and software interrupt;
  - abort for both abort kinds;
  - undefined for undefined instruction;
  - interrupt for a normal interrupt;
  - fast-interrupt for a fast interrupt.
- R5: In `new_psr`, bit 6 (interrupt mask) is always 1. Bit 5 (fast mask) is set to 1 for a fast interrupt or reset and is otherwise copied from the current word. All other bits are copied from the current word.
- R6: `saved_psr` equals the status word as it was before the entry, and this value is stored in the target mode's bank.
- R7: `link_addr` equals the current PC minus 4, and this value is stored in the target mode's bank.
- R8: A normal interrupt request is ignored while bit 6 is set. A fast interrupt request is ignored while bit 5 is set.
- R9: `taken` is a one-cycle pulse in the cycle after the request. In that pulse cycle, requests and return commands are ignored.
- R10: A return command produces `restore_valid` in the next cycle. The restored status word comes from the current mode's bank. The restored PC is that bank's return address, less 4 when `ret_sub4` is 1.
- R11: A return command is ignored when the current mode has no bank (user, system or any other code), or when an eligible request arrives in the same cycle.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_reset | input | 1 | Reset exception request |
| req_undef | input | 1 | Undefined instruction request |
| req_swi | input | 1 | Software interrupt request |
| req_pabt | input | 1 | Prefetch abort request |
| req_dabt | input | 1 | Data abort request |
| req_irq | input | 1 | Normal interrupt request |
| req_fiq | input | 1 | Fast interrupt request |
| cur_pc | input | AW | Current PC of the core |
| cur_psr | input | PSR_W | Current status word |
| ret_req | input | 1 | Return command |
| ret_sub4 | input | 1 | Subtract 4 from the stored return address on return |
| taken | output | 1 | Entry pulse |
| taken_id | output | 3 | Identifier of the entered exception |
| new_psr | output | PSR_W | Status word after entry |
| saved_psr | output | PSR_W | Status word before entry |
| link_addr | output | AW | Return address stored on entry |
| vector | output | AW | Vector address to load into the PC |
| restore_valid | output | 1 | Restore pulse |
| restore_psr | output | PSR_W | Status word restored on return |
| restore_pc | output | AW | PC restored on return |

## Verification
A wrong winner or a stale mask shows up one cycle after the request, as a wrong `taken_id`, `vector` or `new_psr` on the pulse. A bank written with the wrong index or data stays hidden until a later return from that mode, where `restore_psr` or `restore_pc` differs from the stored values. For that reason, the random stimulus mixes returns from every mode with entries. A state machine stuck outside `ST_IDLE` shows up as missing pulses on the very next request.

// File: rtl/exc_pkg.sv
package exc_pkg;

    typedef enum logic [2:0] {
        EX_RESET = 3'd0,
        EX_UNDEF = 3'd1,
        EX_SWI   = 3'd2,
        EX_PABT  = 3'd3,
        EX_DABT  = 3'd4,
        EX_RSVD  = 3'd5,
        EX_IRQ   = 3'd6,
        EX_FIQ   = 3'd7
    } exc_id_t;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ENTRY  = 2'd1,
        ST_RETURN = 2'd2
    } seq_state_t;

    localparam int MODE_W   = 5;
    localparam int FMASK_B  = 5;
    localparam int IMASK_B  = 6;
    localparam int NUM_BANK = 5;
    localparam int BANK_W   = 3;

    localparam logic [MODE_W-1:0] MD_USER = 5'h00;
    localparam logic [MODE_W-1:0] MD_SYS  = 5'h01;
    localparam logic [MODE_W-1:0] MD_FIQ  = 5'h02;
    localparam logic [MODE_W-1:0] MD_IRQ  = 5'h03;
    localparam logic [MODE_W-1:0] MD_SVC  = 5'h04;
    localparam logic [MODE_W-1:0] MD_ABT  = 5'h05;
    localparam logic [MODE_W-1:0] MD_UND  = 5'h06;

    function automatic logic [MODE_W-1:0] mode_of(exc_id_t id);
        logic [MODE_W-1:0] m;
        unique case (id)
            EX_RESET, EX_SWI: m = MD_SVC;
            EX_PABT, EX_DABT: m = MD_ABT;
            EX_UNDEF:         m = MD_UND;
            EX_IRQ:           m = MD_IRQ;
            EX_FIQ:           m = MD_FIQ;
            default:          m = MD_SVC;
        endcase
        return m;
    endfunction

    function automatic logic bank_valid(logic [MODE_W-1:0] m);
        return (m == MD_FIQ) || (m == MD_IRQ) || (m == MD_SVC) ||
               (m == MD_ABT) || (m == MD_UND);
    endfunction

    function automatic logic [BANK_W-1:0] bank_of(logic [MODE_W-1:0] m);
        logic [BANK_W-1:0] b;
        case (m)
            MD_FIQ:  b = 3'd0;
            MD_IRQ:  b = 3'd1;
            MD_SVC:  b = 3'd2;
            MD_ABT:  b = 3'd3;
            MD_UND:  b = 3'd4;
            default: b = 3'd0;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
    import exc_pkg::*;
(
    input  logic    req_reset,
    input  logic    req_undef,
    input  logic    req_swi,
    input  logic    req_pabt,
    input  logic    req_dabt,
    input  logic    req_irq,
    input  logic    req_fiq,
    input  logic    irq_masked,
    input  logic    fiq_masked,
    output logic    hit,
    output exc_id_t win_id
);

    // Lowest priority first; each later line overrides the earlier ones.
    always_comb begin
        hit    = 1'b0;
        win_id = EX_RESET;
        if (req_swi)                  begin hit = 1'b1; win_id = EX_SWI;   end
        if (req_undef)                begin hit = 1'b1; win_id = EX_UNDEF; end
        if (req_pabt)                 begin hit = 1'b1; win_id = EX_PABT;  end
        if (req_irq && !irq_masked)   begin hit = 1'b1; win_id = EX_IRQ;   end
        if (req_fiq && !fiq_masked)   begin hit = 1'b1; win_id = EX_FIQ;   end
        if (req_dabt)                 begin hit = 1'b1; win_id = EX_DABT;  end
        if (req_reset)                begin hit = 1'b1; win_id = EX_RESET; end
    end

endmodule

// File: rtl/exc_bank.sv
module exc_bank #(
    parameter int AW     = 32,
    parameter int PSR_W  = 32,
    parameter int NB     = 5,
    parameter int IDX_W  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [PSR_W-1:0] wr_psr,
    input  logic [AW-1:0]    wr_lr,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [PSR_W-1:0] rd_psr,
    output logic [AW-1:0]    rd_lr
);

    logic [PSR_W-1:0] psr_arr [NB];
    logic [AW-1:0]    lr_arr  [NB];

    for (genvar b = 0; b < NB; b++) begin : g_bank
        logic [PSR_W-1:0] psr_q;
        logic [AW-1:0]    lr_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                psr_q <= '0;
                lr_q  <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(b))) begin
                psr_q <= wr_psr;
                lr_q  <= wr_lr;
            end
        end

        assign psr_arr[b] = psr_q;
        assign lr_arr[b]  = lr_q;
    end

    always_comb begin
        rd_psr = '0;
        rd_lr  = '0;
        for (int b = 0; b < NB; b++) begin
            if (rd_idx == IDX_W'(b)) begin
                rd_psr = psr_arr[b];
                rd_lr  = lr_arr[b];
            end
        end
    end

endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
    import exc_pkg::*;
#(
    parameter int          AW       = 32,
    parameter int          PSR_W    = 32,
    parameter logic [31:0] VEC_BASE = 32'h0000_0000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_reset,
    input  logic             req_undef,
    input  logic             req_swi,
    input  logic             req_pabt,
    input  logic             req_dabt,
    input  logic             req_irq,
    input  logic             req_fiq,
    input  logic [AW-1:0]    cur_pc,
    input  logic [PSR_W-1:0] cur_psr,
    input  logic             ret_req,
    input  logic             ret_sub4,
    output logic             taken,
    output logic [2:0]       taken_id,
    output logic [PSR_W-1:0] new_psr,
    output logic [PSR_W-1:0] saved_psr,
    output logic [AW-1:0]    link_addr,
    output logic [AW-1:0]    vector,
    output logic             restore_valid,
    output logic [PSR_W-1:0] restore_psr,
    output logic [AW-1:0]    restore_pc
);

    localparam logic [AW-1:0] RET_OFS = AW'(4);
    localparam logic [AW-1:0] VBASE   = AW'(VEC_BASE);

    seq_state_t        state, state_nx;
    logic              hit;
    exc_id_t           win_id;
    logic              accept;
    logic              do_entry;
    logic              do_ret;
    logic [MODE_W-1:0] cur_mode;
    logic [MODE_W-1:0] tgt_mode;
    logic [PSR_W-1:0]  entry_psr;
    logic [PSR_W-1:0]  bank_psr;
    logic [AW-1:0]     bank_lr;

    assign cur_mode = cur_psr[MODE_W-1:0];
    assign accept   = (state == ST_IDLE);

    exc_arbiter u_arb (
        .req_reset  (req_reset),
        .req_undef  (req_undef),
        .req_swi    (req_swi),
        .req_pabt   (req_pabt),
        .req_dabt   (req_dabt),
        .req_irq    (req_irq),
        .req_fiq    (req_fiq),
        .irq_masked (cur_psr[IMASK_B]),
        .fiq_masked (cur_psr[FMASK_B]),
        .hit        (hit),
        .win_id     (win_id)
    );

    assign tgt_mode = mode_of(win_id);
    assign do_entry = accept && hit;
    assign do_ret   = accept && !hit && ret_req && bank_valid(cur_mode);

    always_comb begin
        entry_psr                 = cur_psr;
        entry_psr[MODE_W-1:0]     = tgt_mode;
        entry_psr[IMASK_B]        = 1'b1;
        if (win_id == EX_FIQ || win_id == EX_RESET)
            entry_psr[FMASK_B]    = 1'b1;
    end

    exc_bank #(
        .AW    (AW),
        .PSR_W (PSR_W),
        .NB    (NUM_BANK),
        .IDX_W (BANK_W)
    ) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (do_entry),
        .wr_idx (bank_of(tgt_mode)),
        .wr_psr (cur_psr),
        .wr_lr  (cur_pc - RET_OFS),
        .rd_idx (bank_of(cur_mode)),
        .rd_psr (bank_psr),
        .rd_lr  (bank_lr)
    );

    // Next-state logic: take / resume / settle.
    always_comb begin
        state_nx = ST_IDLE;
        unique case (state)
            ST_IDLE: begin
                if (do_entry)    state_nx = ST_ENTRY;
                else if (do_ret) state_nx = ST_RETURN;
                else             state_nx = ST_IDLE;
            end
            ST_ENTRY:  state_nx = ST_IDLE;
            ST_RETURN: state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Output registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            taken_id    <= '0;
            new_psr     <= '0;
            saved_psr   <= '0;
            link_addr   <= '0;
            vector      <= '0;
            restore_psr <= '0;
            restore_pc  <= '0;
        end else begin
            if (do_entry) begin
                taken_id  <= win_id;
                new_psr   <= entry_psr;
                saved_psr <= cur_psr;
                link_addr <= cur_pc - RET_OFS;
                vector    <= VBASE + AW'({win_id, 2'b00});
            end
            if (do_ret) begin
                restore_psr <= bank_psr;
                restore_pc  <= ret_sub4 ? (bank_lr - RET_OFS) : bank_lr;
            end
        end
    end

    assign taken         = (state == ST_ENTRY);
    assign restore_valid = (state == ST_RETURN);

    a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        taken |=> (!taken && !restore_valid));

    a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(taken && restore_valid));

    a_r5_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
        taken |-> new_psr[IMASK_B]);

    a_r5_fiq_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (taken && (taken_id == EX_FIQ || taken_id == EX_RESET)) |-> new_psr[FMASK_B]);

    a_r3_vector_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        taken |-> (vector[1:0] == 2'b00));

    a_r8_irq_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && req_irq && cur_psr[IMASK_B] && !req_reset && !req_undef &&
         !req_swi && !req_pabt && !req_dabt && !(req_fiq && !cur_psr[FMASK_B]))
        |=> !taken);

    a_r11_user_return: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && ret_req && cur_mode == MD_USER) |=> !restore_valid);

endmodule

// File: tb/tb_exc_entry_seq.sv
`timescale 1ns/1ps
module tb_exc_entry_seq;

    localparam int AW    = 32;
    localparam int PSR_W = 32;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_reset = 0, req_undef = 0, req_swi = 0, req_pabt = 0;
    logic             req_dabt = 0, req_irq = 0, req_fiq = 0;
    logic [AW-1:0]    cur_pc = '0;
    logic [PSR_W-1:0] cur_psr = '0;
    logic             ret_req = 0, ret_sub4 = 0;
    logic             taken, restore_valid;
    logic [2:0]       taken_id;
    logic [PSR_W-1:0] new_psr, saved_psr, restore_psr;
    logic [AW-1:0]    link_addr, vector, restore_pc;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    exc_entry_seq dut (
        .clk(clk), .rst_n(rst_n),
        .req_reset(req_reset), .req_undef(req_undef), .req_swi(req_swi),
        .req_pabt(req_pabt), .req_dabt(req_dabt), .req_irq(req_irq), .req_fiq(req_fiq),
        .cur_pc(cur_pc), .cur_psr(cur_psr), .ret_req(ret_req), .ret_sub4(ret_sub4),
        .taken(taken), .taken_id(taken_id), .new_psr(new_psr), .saved_psr(saved_psr),
        .link_addr(link_addr), .vector(vector), .restore_valid(restore_valid),
        .restore_psr(restore_psr), .restore_pc(restore_pc)
    );

    // Bench model of the banks (order: fast, irq, svc, abort, undef).
    logic [PSR_W-1:0] m_psr [5];
    logic [AW-1:0]    m_lr  [5];

    // Pending expectations for the next sampled cycle.
    logic             e_taken = 0, e_rv = 0;
    logic [2:0]       e_id;
    logic [PSR_W-1:0] e_npsr, e_saved, e_rpsr;
    logic [AW-1:0]    e_link, e_vec, e_rpc;
    string            tag_t = "R9", tag_r = "R10";

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int bank_idx(logic [4:0] m);
        case (m)
            5'h02: return 0;
            5'h03: return 1;
            5'h04: return 2;
            5'h05: return 3;
            5'h06: return 4;
            default: return -1;
        endcase
    endfunction

    function automatic logic [4:0] tgt_mode(int id);
        case (id)
            0, 2: return 5'h04;
            3, 4: return 5'h05;
            1:    return 5'h06;
            6:    return 5'h03;
            default: return 5'h02;
        endcase
    endfunction

    // Returns the winning identifier, or -1 when nothing is eligible.
    function automatic int winner(logic [6:0] r, logic [PSR_W-1:0] psr);
        // r = {fiq, irq, dabt, pabt, swi, undef, reset}
        if (r[0]) return 0;
        if (r[4]) return 4;
        if (r[6] && !psr[5]) return 7;
        if (r[5] && !psr[6]) return 6;
        if (r[3]) return 3;
        if (r[1]) return 1;
        if (r[2]) return 2;
        return -1;
    endfunction

    task automatic check_cycle();
        chk(tag_t, 64'(taken), 64'(e_taken));
        if (e_taken) begin
            chk("R2", 64'(taken_id), 64'(e_id));
            chk("R3", 64'(vector), 64'(e_vec));
            chk("R4", 64'(new_psr[4:0]), 64'(e_npsr[4:0]));
            chk("R5", 64'(new_psr), 64'(e_npsr));
            chk("R6", 64'(saved_psr), 64'(e_saved));
            chk("R7", 64'(link_addr), 64'(e_link));
        end
        chk(tag_r, 64'(restore_valid), 64'(e_rv));
        if (e_rv) begin
            chk("R10", 64'(restore_psr), 64'(e_rpsr));
            chk("R10", 64'(restore_pc), 64'(e_rpc));
        end
    endtask

    // Called at a negative edge: check the current cycle, then drive the next.
    task automatic step(logic [6:0] r, logic [AW-1:0] pc, logic [PSR_W-1:0] psr,
                        logic rt, logic s4);
        bit busy;
        int w;
        int bi;
        check_cycle();
        busy = e_taken || e_rv;
        {req_fiq, req_irq, req_dabt, req_pabt, req_swi, req_undef, req_reset} = r;
        cur_pc = pc; cur_psr = psr; ret_req = rt; ret_sub4 = s4;
        e_taken = 0; e_rv = 0; tag_t = "R9"; tag_r = "R10";
        w = winner(r, psr);
        if ((r[5] && psr[6]) || (r[6] && psr[5])) tag_t = "R8";
        if (busy) begin
            tag_t = "R9"; tag_r = "R9";
        end else if (w >= 0) begin
            e_taken = 1;
            e_id = 3'(w);
            e_vec = AW'(w * 4);
            e_saved = psr;
            e_link = pc - 4;
            e_npsr = psr;
            e_npsr[4:0] = tgt_mode(w);
            e_npsr[6] = 1'b1;
            if (w == 7 || w == 0) e_npsr[5] = 1'b1;
            bi = bank_idx(tgt_mode(w));
            m_psr[bi] = psr;
            m_lr[bi] = pc - 4;
            if (rt) tag_r = "R11";
        end else if (rt) begin
            bi = bank_idx(psr[4:0]);
            if (bi < 0) tag_r = "R11";
            else begin
                e_rv = 1;
                e_rpsr = m_psr[bi];
                e_rpc = s4 ? m_lr[bi] - 4 : m_lr[bi];
            end
        end
        @(negedge clk);
    endtask

    function automatic logic [PSR_W-1:0] rnd_psr();
        logic [PSR_W-1:0] p;
        logic [4:0] modes [8] = '{5'h00, 5'h01, 5'h02, 5'h03, 5'h04, 5'h05, 5'h06, 5'h1F};
        p = $urandom();
        p[4:0] = modes[$urandom_range(0, 7)];
        return p;
    endfunction

    initial begin
        #(4 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd20577);
        for (int b = 0; b < 5; b++) begin m_psr[b] = '0; m_lr[b] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle after reset release
        chk("R1", 64'(taken), 64'd0);
        chk("R1", 64'(restore_valid), 64'd0);
        @(negedge clk);
        chk("R1", 64'(taken), 64'd0);

        // Directed corners.
        step(7'h7F, 32'h100, 32'h0000_0000, 1'b0, 1'b0);   // R2: all at once -> reset
        step(7'h00, 32'h0, 32'h0, 1'b0, 1'b0);
        step(7'h60, 32'h204, 32'h0000_0020, 1'b0, 1'b0);   // R8: fast masked -> irq
        step(7'h00, 32'h0, 32'h0, 1'b0, 1'b0);
        step(7'h20, 32'h300, 32'h0000_0040, 1'b0, 1'b0);   // R8: irq masked, ignored
        step(7'h00, 32'h0, 32'h0000_0000, 1'b1, 1'b0);     // R11: return in user mode
        step(7'h10, 32'h400, 32'h0000_0001, 1'b0, 1'b0);   // data abort
        step(7'h10, 32'h500, 32'h0000_0001, 1'b0, 1'b0);   // R9: held, ignored
        step(7'h00, 32'h0, 32'h0000_0005, 1'b1, 1'b1);     // R10: return minus 4
        step(7'h00, 32'h0, 32'h0000_0005, 1'b1, 1'b0);     // R9: ignored in pulse
        step(7'h02, 32'h604, 32'h0000_0003, 1'b1, 1'b0);   // R11: entry beats return
        step(7'h00, 32'h0, 32'h0, 1'b0, 1'b0);

        // Random mix.
        for (int i = 0; i < 4000; i++) begin
            logic [6:0] r;
            r[0] = ($urandom_range(0, 31) == 0);
            for (int k = 1; k < 7; k++) r[k] = ($urandom_range(0, 7) == 0);
            step(r, $urandom(), rnd_psr(), ($urandom_range(0, 2) == 0), 1'($urandom()));
        end
        step(7'h00, 32'h0, 32'h0, 1'b0, 1'b0);
        check_cycle();

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule